// File: doc/BRIEF.md
# USB Device Bus-Event Interrupt Controller

This block collects the line-state and error conditions of a full-speed USB device controller and reports them as eight sticky flags behind one interrupt request. It is fed by the decoded bus state (line idle or not, bus reset seen) and by one-cycle status pulses from the packet and endpoint logic. These pulses mark a received SOF token, a received SETUP, an isochronous CRC or bit-stuff error, an endpoint underflow or overflow, and a STALL handshake sent. Software enables each flag on its own and clears a flag by writing a 1 to its bit.

An idle timer counts consecutive idle clock cycles. When the count reaches a parameter that stands for 3 ms at the system clock, the block sets the suspend flag and enters the suspended state. The first non-idle line state seen in that state sets the resume flag and leaves it. A bus reset also leaves it. A wake output is driven by gates only, so the resume condition can raise it while the clock is stopped. Four one-cycle event strobes go to other peripherals: SETUP, start of frame, isochronous CRC error, and a shared underflow-or-overflow strobe.

Top module: `usb_bus_evt_irq`

## Requirements
- R1: After reset, flags_o, irq_o, suspended_o and all event strobes are 0.
- R2: A source sampled high at a rising edge sets its flag, visible after that edge. Bit positions are: 0 start of frame, 1 suspend, 2 resume, 3 bus reset, 4 isochronous CRC error, 5 underflow, 6 overflow, 7 STALL.
- R3: A flag stays set until a clear write (clr_we_i high) has a 1 in its bit of clr_mask_i. A set and a clear of the same bit in the same cycle leave the bit set.
- R4: irq_o is registered and equals the OR over all bits of (flag AND en_i), using the flags and en_i of the same edge.
- R5: When line_idle_i has been sampled high at IDLE_CYCLES consecutive edges, the suspend flag and suspended_o are set after the last of them. After IDLE_CYCLES-1 such edges, neither is set.
- R6: The suspend flag is set once per idle period. It is not set again while the line stays idle. Any non-idle cycle or bus reset restarts the count.
- R7: The resume flag is set only by a non-idle line while suspended_o is 1, and that cycle clears suspended_o. A non-idle line while not suspended has no effect on the resume flag.
- R8: bus_rst_i sets the bus reset flag, clears suspended_o at the next edge, and restarts the idle count.
- R9: iso_err_i sets the CRC flag and its event only when iso_ep_i is high in the same cycle.
- R10: wake_o is combinational and equals suspended_o AND NOT line_idle_i. It needs no clock edge.
- R11: Each event strobe is high for exactly one cycle, one edge after the rising edge of its source. The shared strobe's source is underflow OR overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_idle_i | input | 1 | Decoded line is in the idle state |
| bus_rst_i | input | 1 | Bus reset condition detected |
| sof_i | input | 1 | SOF token received |
| setup_i | input | 1 | SETUP token received |
| iso_err_i | input | 1 | CRC or bit-stuff error in incoming packet |
| iso_ep_i | input | 1 | Packet in error is addressed to an isochronous endpoint |
| underflow_i | input | 1 | Endpoint could not supply data to the host |
| overflow_i | input | 1 | Endpoint could not accept data from the host |
| stall_i | input | 1 | STALL handshake returned to the host |
| en_i | input | 8 | Per-flag interrupt enables |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 8 | Write-one-to-clear mask |
| flags_o | output | 8 | Sticky flags |
| irq_o | output | 1 | Combined bus-event interrupt request |
| suspended_o | output | 1 | Device is in the suspended state |
| wake_o | output | 1 | Clockless resume wake request |
| ev_setup_o | output | 1 | SETUP event strobe |
| ev_sof_o | output | 1 | Start-of-frame event strobe |
| ev_crc_o | output | 1 | Isochronous CRC error event strobe |
| ev_xflow_o | output | 1 | Underflow-or-overflow event strobe |

## Verification
Two pairs of functions can fall on the same edge. A source can set a flag while software clears it, and a bus reset can arrive while the idle timer is about to expire. The directed part sets and clears the same bit in one write and expects the bit to stay set. The random part asserts bus reset, clears and every source with independent probabilities during long idle runs. A bench model built from the requirements predicts the flags, the interrupt, the suspended state and the strobes at every edge, and each output is compared with it.

// File: rtl/usb_bev_pkg.sv
package usb_bev_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned B_SOF    = 0;
  localparam int unsigned B_SUSP   = 1;
  localparam int unsigned B_RESUME = 2;
  localparam int unsigned B_BUSRST = 3;
  localparam int unsigned B_CRC    = 4;
  localparam int unsigned B_UNDER  = 5;
  localparam int unsigned B_OVER   = 6;
  localparam int unsigned B_STALL  = 7;
  localparam int unsigned NEVT = 4;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/usb_bev_idle.sv
module usb_bev_idle #(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_idle_i,
  input  logic bus_rst_i,
  output logic susp_hit_o,
  output logic resume_hit_o,
  output logic suspended_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          susp_q;

  assign susp_hit_o   = line_idle_i && !bus_rst_i && (cnt_q == LAST);
  assign resume_hit_o = susp_q && !line_idle_i;
  assign suspended_o  = susp_q;

  always_ff @(posedge clk) begin
    if (rst || !line_idle_i || bus_rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst_i || resume_hit_o) begin
      susp_q <= 1'b0;
    end else if (susp_hit_o) begin
      susp_q <= 1'b1;
    end
  end

  p_enter_susp_r5: assert property (@(posedge clk) disable iff (rst)
    susp_hit_o |=> susp_q);
  p_leave_on_rst_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> !susp_q);
  p_one_per_period_r6: assert property (@(posedge clk) disable iff (rst)
    (susp_hit_o && line_idle_i) |=> !susp_hit_o);
endmodule

// File: rtl/usb_bev_flags.sv
module usb_bev_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q, flags_d;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      flags_d[i] = set_i[i] | (flags_q[i] & ~(clr_we_i & clr_mask_i[i]));
    end
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !(clr_we_i && clr_mask_i[i])) |=> flags_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_d & en_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  p_irq_has_flag_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|flags_q));
endmodule

// File: rtl/usb_bev_strobe.sv
module usb_bev_strobe #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] prev_q, pulse_q;

  for (genvar i = 0; i < W; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i]  <= 1'b0;
        pulse_q[i] <= 1'b0;
      end else begin
        prev_q[i]  <= lvl_i[i];
        pulse_q[i] <= lvl_i[i] & ~prev_q[i];
      end
    end
    p_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
      pulse_q[i] |=> !pulse_q[i]);
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/usb_bus_evt_irq.sv
module usb_bus_evt_irq
  import usb_bev_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_idle_i,
  input  logic            bus_rst_i,
  input  logic            sof_i,
  input  logic            setup_i,
  input  logic            iso_err_i,
  input  logic            iso_ep_i,
  input  logic            underflow_i,
  input  logic            overflow_i,
  input  logic            stall_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] flags_o,
  output logic            irq_o,
  output logic            suspended_o,
  output logic            wake_o,
  output logic            ev_setup_o,
  output logic            ev_sof_o,
  output logic            ev_crc_o,
  output logic            ev_xflow_o
);
  logic     susp_hit, resume_hit, susp_st, crc_hit;
  src_vec_t set_v;
  logic [NEVT-1:0] ev_lvl, ev_pls;

  usb_bev_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .line_idle_i(line_idle_i), .bus_rst_i(bus_rst_i),
    .susp_hit_o(susp_hit), .resume_hit_o(resume_hit), .suspended_o(susp_st)
  );

  assign crc_hit = iso_err_i & iso_ep_i;

  always_comb begin
    set_v           = '0;
    set_v[B_SOF]    = sof_i;
    set_v[B_SUSP]   = susp_hit;
    set_v[B_RESUME] = resume_hit;
    set_v[B_BUSRST] = bus_rst_i;
    set_v[B_CRC]    = crc_hit;
    set_v[B_UNDER]  = underflow_i;
    set_v[B_OVER]   = overflow_i;
    set_v[B_STALL]  = stall_i;
  end

  usb_bev_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .en_i(en_i), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .flags_o(flags_o), .irq_o(irq_o)
  );

  assign ev_lvl = {underflow_i | overflow_i, crc_hit, sof_i, setup_i};

  usb_bev_strobe #(.W(NEVT)) u_ev (
    .clk(clk), .rst(rst), .lvl_i(ev_lvl), .pulse_o(ev_pls)
  );

  assign ev_setup_o  = ev_pls[0];
  assign ev_sof_o    = ev_pls[1];
  assign ev_crc_o    = ev_pls[2];
  assign ev_xflow_o  = ev_pls[3];
  assign suspended_o = susp_st;
  assign wake_o      = susp_st & ~line_idle_i;

  p_resume_needs_susp_r7: assert property (@(posedge clk) disable iff (rst)
    (!susp_st && !flags_o[B_RESUME]) |=> !flags_o[B_RESUME]);
  p_crc_iso_only_r9: assert property (@(posedge clk) disable iff (rst)
    (iso_err_i && !iso_ep_i && !flags_o[B_CRC]) |=> !flags_o[B_CRC]);
endmodule

// File: tb/tb_usb_bus_evt_irq.sv
`timescale 1ns/1ps
module tb_usb_bus_evt_irq;
  localparam int unsigned N = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic idle = 0, brst = 0, sof = 0, setup = 0, crc = 0, iso = 0;
  logic und = 0, ovf = 0, stall = 0, cwe = 0;
  logic [7:0] en = 0, cmask = 0;
  logic [7:0] flags;
  logic irq, susp, wake, e_setup, e_sof, e_crc, e_xf;

  int n_cmp = 0, n_bad = 0;

  logic [7:0] m_flags;
  logic m_irq, m_susp;
  int unsigned m_cnt;
  logic [3:0] m_prev, m_ev;

  always #5 clk = ~clk;

  usb_bus_evt_irq #(.IDLE_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .line_idle_i(idle), .bus_rst_i(brst), .sof_i(sof),
    .setup_i(setup), .iso_err_i(crc), .iso_ep_i(iso), .underflow_i(und),
    .overflow_i(ovf), .stall_i(stall), .en_i(en), .clr_we_i(cwe),
    .clr_mask_i(cmask), .flags_o(flags), .irq_o(irq), .suspended_o(susp),
    .wake_o(wake), .ev_setup_o(e_setup), .ev_sof_o(e_sof), .ev_crc_o(e_crc),
    .ev_xflow_o(e_xf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_flags = 0; m_irq = 0; m_susp = 0; m_cnt = 0; m_prev = 0; m_ev = 0;
  endtask

  // One edge: predict from inputs, advance, compare all outputs.
  task automatic tick();
    logic hit, res;
    logic [7:0] set, clr, nf;
    logic [3:0] lvl;
    hit = idle && !brst && (m_cnt == N - 1);
    res = m_susp && !idle;
    set = {stall, ovf, und, crc & iso, brst, res, hit, sof};
    clr = cwe ? cmask : 8'h00;
    nf  = (m_flags & ~clr) | set;
    lvl = {und | ovf, crc & iso, sof, setup};
    @(posedge clk);
    #1;
    m_flags = nf;
    m_irq   = |(nf & en);
    if (brst || res) m_susp = 1'b0;
    else if (hit)    m_susp = 1'b1;
    if (!idle || brst) m_cnt = 0;
    else if (m_cnt != N) m_cnt++;
    m_ev   = lvl & ~m_prev;
    m_prev = lvl;
    chk(flags == m_flags, "R2 flags", flags, m_flags);
    chk(irq == m_irq, "R4 irq", irq, m_irq);
    chk(susp == m_susp, "R5 suspended", susp, m_susp);
    chk({e_xf, e_crc, e_sof, e_setup} == m_ev, "R11 events",
        {e_xf, e_crc, e_sof, e_setup}, m_ev);
    chk(wake == (m_susp & ~idle), "R10 wake", wake, m_susp & ~idle);
  endtask

  task automatic clear_all();
    cwe = 1; cmask = 8'hFF; tick(); cwe = 0; cmask = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    model_reset();
    chk(flags == 0 && irq == 0 && susp == 0 && {e_xf, e_crc, e_sof, e_setup} == 0,
        "R1 reset", {flags, irq, susp}, 0);
    chk(wake == 0, "R1 wake after reset", wake, 0);

    // R2: each source alone, line busy
    en = 8'hFF;
    sof = 1; tick(); sof = 0;
    chk(flags == 8'h01, "R2 sof bit0", flags, 8'h01);
    clear_all();
    und = 1; tick(); und = 0;
    chk(flags == 8'h20, "R2 underflow bit5", flags, 8'h20);
    clear_all();
    ovf = 1; tick(); ovf = 0;
    chk(flags == 8'h40 && e_xf, "R11 overflow strobe", {flags, e_xf}, {8'h40, 1'b1});
    tick();
    chk(!e_xf, "R11 strobe one cycle", e_xf, 0);
    clear_all();
    stall = 1; tick(); stall = 0;
    chk(flags == 8'h80, "R2 stall bit7", flags, 8'h80);
    clear_all();

    // R9: CRC only for iso endpoint
    crc = 1; iso = 0; tick();
    chk(flags[4] == 0 && !e_crc, "R9 non-iso ignored", {flags[4], e_crc}, 0);
    crc = 0; tick();
    crc = 1; iso = 1; tick(); crc = 0; iso = 0;
    chk(flags[4] == 1 && e_crc, "R9 iso sets", {flags[4], e_crc}, 2'b11);
    clear_all();

    // R3: set and clear together
    sof = 1; cwe = 1; cmask = 8'h01; tick(); sof = 0; cwe = 0; cmask = 0;
    chk(flags[0] == 1, "R3 set beats clear", flags[0], 1);
    tick();
    chk(flags[0] == 1, "R3 sticky", flags[0], 1);
    cwe = 1; cmask = 8'h01; tick(); cwe = 0; cmask = 0;
    chk(flags[0] == 0, "R3 w1c", flags[0], 0);

    // R4: masking
    en = 8'h00; stall = 1; tick(); stall = 0;
    chk(irq == 0, "R4 masked", irq, 0);
    en = 8'h80; tick();
    chk(irq == 1, "R4 enabled", irq, 1);
    clear_all();

    // R5/R6: threshold
    idle = 1;
    repeat (N - 1) tick();
    chk(susp == 0 && flags[1] == 0, "R5 N-1 no suspend", {susp, flags[1]}, 0);
    tick();
    chk(susp == 1 && flags[1] == 1, "R5 N suspend", {susp, flags[1]}, 2'b11);
    clear_all();
    repeat (2 * N) tick();
    chk(flags[1] == 0, "R6 once per period", flags[1], 0);

    // R10: wake without an edge
    chk(wake == 0, "R10 wake low while idle", wake, 0);
    @(negedge clk); idle = 0; #1;
    chk(wake == 1, "R10 wake combinational", wake, 1);
    tick();
    chk(flags[2] == 1 && susp == 0, "R7 resume sets, leaves", {flags[2], susp}, 2'b10);
    clear_all();

    // R7: ignored when awake
    idle = 1; repeat (3) tick(); idle = 0; repeat (3) tick();
    chk(flags[2] == 0, "R7 awake non-idle ignored", flags[2], 0);

    // R8: reset exits suspend
    idle = 1; repeat (N + 2) tick();
    chk(susp == 1, "R8 suspended before reset", susp, 1);
    brst = 1; tick(); brst = 0;
    chk(susp == 0 && flags[3] == 1, "R8 reset exits", {susp, flags[3]}, 2'b01);
    repeat (N - 1) tick();
    chk(susp == 0, "R8 count restarted", susp, 0);
    tick();
    chk(susp == 1, "R8 suspend after full recount", susp, 1);
    idle = 0; tick(); clear_all();

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      sof   = ($urandom % 8) == 0;
      setup = ($urandom % 10) == 0;
      crc   = ($urandom % 12) == 0;
      iso   = ($urandom % 2) == 0;
      und   = ($urandom % 15) == 0;
      ovf   = ($urandom % 15) == 0;
      stall = ($urandom % 20) == 0;
      brst  = ($urandom % 300) == 0;
      if (($urandom % 40) == 0) idle = ~idle;
      cwe   = ($urandom % 6) == 0;
      cmask = 8'($urandom);
      if (($urandom % 50) == 0) en = 8'($urandom);
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule